// File: doc/BRIEF.md
# Composite Gray / Low-Probe Binary Counter

This block is an N-bit up counter that keeps its state in a code where no increment has to touch more than three bits. The low N-4 bits, called the fast field, step through a binary-reflected Gray code and change exactly one bit per increment. The top four bits, called the slow field, step through a fixed sixteen-entry code chosen so that the next code can be decided by looking at only three of its bits and reached by changing at most two of them. The slow field moves only on the increment that returns the fast field to all zeros. So an increment writes at most three bits and reads at most N-1 bits.

The block is meant for storage where every bit access has a cost, such as wear-limited or slow state cells. The counter shows its raw state. It also shows the ordinary binary value that the state stands for. For the step that the `inc` input would take on the next edge, it gives a mask of the bits the step examines and a mask of the bits it rewrites.

Top module: `gcnt_top`

## Requirements
- R1: While `rst_n` is low, every state bit is 0 and `count` is 0, whatever the clock and `inc` do.
- R2: When `inc` is low on a rising clock edge, `state` keeps its value, and both `rd_mask` and `wr_mask` are all zeros.
- R3: The fast field `state[N-5:0]` is a reflected Gray code. When its parity is even, an increment inverts bit 0. When its parity is odd, an increment inverts the bit one place above the lowest 1, and the code with only its top bit set goes to all zeros. Each increment changes exactly one fast-field bit.
- R4: The slow field `state[N-1:N-4]` changes only on an increment that takes the fast field from its top-bit-only code to all zeros. On every other increment it keeps its value.
- R5: When the slow field advances, it follows this cyclic order of codes (bit 3 on the left): 0000, 0001, 0100, 0101, 1101, 1001, 1100, 1110, 0110, 0111, 1111, 1011, 1000, 1010, 0010, 0011, and then back to 0000. A code's position in this list is its rank, from 0 to 15.
- R6: `count` equals rank(slow field) * 2^(N-4) plus the binary value of the fast-field Gray code. Each increment raises it by exactly 1, modulo 2^N.
- R7: When `inc` is high, `wr_mask` has a 1 at each state bit that the coming edge will change. It never has more than three 1s.
- R8: When `inc` is high, `rd_mask` has a 1 at every fast-field bit. On a wrapping increment it also marks three slow-field bits, chosen from the slow field's current value c: bits {3,1,0} if c[0]=0, bits {2,1,0} if c[0]=1 and c[2]=0, and bits {3,2,0} otherwise. On other increments it marks no slow-field bits. Every bit set in `wr_mask` is also set in `rd_mask`.
- R9: A slow-field advance changes at most two slow-field bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc | input | 1 | Increment enable, sampled on the rising edge |
| state | output | N | Raw state: slow field in the top 4 bits, Gray fast field below |
| count | output | N | Binary value the state stands for |
| rd_mask | output | N | State bits examined by the pending increment |
| wr_mask | output | N | State bits rewritten by the pending increment |

## Verification
The rarest event is a slow-field advance. It happens only once in every 2^(N-4) increments, and every one of the sixteen slow-field transitions has to be reached with the correct read mask. The stimulus therefore uses N=8 and runs one unbroken run of 256 increments, which crosses every slow-field transition, including the one that returns the whole counter to zero. At each step it compares the state and both masks with values built from an independent binary reference count. Directed cases then cover reset in the middle of a count and idle cycles that must leave the state and masks unchanged.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

  localparam int SLOW_W = 4;

  typedef logic [SLOW_W-1:0] slow_t;

  // Rank of a slow-field code in its cyclic order (R5)
  function automatic logic [SLOW_W-1:0] slow_rank(input slow_t c);
    logic [SLOW_W-1:0] r;
    case (c)
      4'b0000: r = 4'd0;
      4'b0001: r = 4'd1;
      4'b0100: r = 4'd2;
      4'b0101: r = 4'd3;
      4'b1101: r = 4'd4;
      4'b1001: r = 4'd5;
      4'b1100: r = 4'd6;
      4'b1110: r = 4'd7;
      4'b0110: r = 4'd8;
      4'b0111: r = 4'd9;
      4'b1111: r = 4'd10;
      4'b1011: r = 4'd11;
      4'b1000: r = 4'd12;
      4'b1010: r = 4'd13;
      4'b0010: r = 4'd14;
      default: r = 4'd15;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gcnt_gray_step.sv
module gcnt_gray_step #(
  parameter int M = 4
) (
  input  logic [M-1:0] cur,
  output logic [M-1:0] nxt,
  output logic         last
);
  logic par;
  logic found;

  assign par  = ^cur;
  // Only the top bit set: final code of the cycle
  assign last = (cur == {1'b1, {(M-1){1'b0}}});

  always_comb begin
    nxt   = cur;
    found = 1'b0;
    if (!par) begin
      nxt[0] = ~cur[0];
    end else begin
      for (int i = 0; i < M-1; i++) begin
        if (!found && cur[i]) begin
          nxt[i+1] = ~cur[i+1];
          found    = 1'b1;
        end
      end
      if (!found) nxt[M-1] = 1'b0;
    end
  end
endmodule

// File: rtl/gcnt_slow_step.sv
module gcnt_slow_step
  import gcnt_pkg::*;
(
  input  slow_t cur,
  output slow_t nxt,
  output slow_t probe
);
  // Three-probe decision tree: the first probe is bit 0
  always_comb begin
    nxt = cur;
    if (!cur[0]) begin
      probe = 4'b1011;
      if (!cur[1]) begin
        if (!cur[3]) nxt[0] = 1'b1;
        else         nxt[1] = 1'b1;
      end else begin
        if (cur[3])  nxt[3] = 1'b0;
        else         nxt[0] = 1'b1;
      end
    end else if (!cur[2]) begin
      probe  = 4'b0111;
      nxt[0] = 1'b0;
      if (!cur[1]) nxt[2] = 1'b1;
      else         nxt[1] = 1'b0;
    end else begin
      probe = 4'b1101;
      if (!cur[3]) nxt[3] = 1'b1;
      else         nxt[2] = 1'b0;
    end
  end
endmodule

// File: rtl/gcnt_decode.sv
module gcnt_decode
  import gcnt_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-SLOW_W-1:0] fast,
  input  slow_t               slow,
  output logic [N-1:0]        value
);
  localparam int M = N - SLOW_W;

  logic [M-1:0] fast_bin;

  always_comb begin
    fast_bin[M-1] = fast[M-1];
    for (int i = M-2; i >= 0; i--) begin
      fast_bin[i] = fast_bin[i+1] ^ fast[i];
    end
  end

  assign value = {slow_rank(slow), fast_bin};
endmodule

// File: rtl/gcnt_top.sv
module gcnt_top
  import gcnt_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [N-1:0] state,
  output logic [N-1:0] count,
  output logic [N-1:0] rd_mask,
  output logic [N-1:0] wr_mask
);
  localparam int M = N - SLOW_W;

  logic [M-1:0] fast_q, fast_d, fast_nxt;
  slow_t        slow_q, slow_d, slow_nxt, slow_probe;
  logic         fast_last;
  logic         slow_adv;

  gcnt_gray_step #(.M(M)) u_fast (
    .cur  (fast_q),
    .nxt  (fast_nxt),
    .last (fast_last)
  );

  gcnt_slow_step u_slow (
    .cur   (slow_q),
    .nxt   (slow_nxt),
    .probe (slow_probe)
  );

  gcnt_decode #(.N(N)) u_dec (
    .fast  (fast_q),
    .slow  (slow_q),
    .value (count)
  );

  assign slow_adv = inc & fast_last;

  // Next-state process
  always_comb begin
    fast_d = fast_q;
    slow_d = slow_q;
    if (inc)      fast_d = fast_nxt;
    if (slow_adv) slow_d = slow_nxt;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= '0;
      slow_q <= '0;
    end else if (inc) begin
      fast_q <= fast_d;
      slow_q <= slow_d;
    end
  end

  assign state   = {slow_q, fast_q};
  assign wr_mask = {slow_q ^ slow_d, fast_q ^ fast_d};
  assign rd_mask = inc ? {(slow_adv ? slow_probe : 4'b0000), {M{1'b1}}} : '0;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> state == '0); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(state)); // R2
  AST_IDLE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |-> (rd_mask == '0 && wr_mask == '0)); // R2
  AST_FAST_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> $countones(fast_q ^ fast_nxt) == 1); // R3
  AST_SLOW_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !fast_last) |=> $stable(slow_q)); // R4
  AST_FAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && fast_last) |=> fast_q == '0); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == N'($past(count) + 1'b1)); // R6
  AST_WRITE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_mask) <= 3); // R7
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_mask) <= N-1); // R8
  AST_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask & ~rd_mask) == '0); // R8
  AST_SLOW_TWO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slow_q ^ slow_nxt) <= 2); // R9
endmodule

// File: tb/tb_gcnt_top.sv
module tb_gcnt_top;
  localparam int N       = 8;
  localparam int M       = N - 4;
  localparam int CLK_PER = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inc = 1'b0;
  logic [N-1:0] state, count, rd_mask, wr_mask;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Slow-field codes indexed by rank (R5)
  localparam logic [3:0] SEQ [16] = '{
    4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b1101, 4'b1001, 4'b1100, 4'b1110,
    4'b0110, 4'b0111, 4'b1111, 4'b1011, 4'b1000, 4'b1010, 4'b0010, 4'b0011};

  gcnt_top #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .inc(inc),
    .state(state), .count(count), .rd_mask(rd_mask), .wr_mask(wr_mask));

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_state(input int v);
    logic [M-1:0] b;
    b = M'(v);
    return {SEQ[(v >> M) & 15], b ^ (b >> 1)};
  endfunction

  function automatic logic [3:0] probe_of(input logic [3:0] c);
    if (!c[0])      return 4'b1011;
    else if (!c[2]) return 4'b0111;
    else            return 4'b1101;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pre_exp, post_exp, exp_rd;
    bit wraps;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(state == '0, "R1 reset state", state, 0);
    check(count == '0, "R1 reset count", count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Main walk: one full cycle plus the return to zero
    for (int v = 0; v < (1 << N); v++) begin
      pre_exp  = model_state(v);
      post_exp = model_state((v + 1) % (1 << N));
      wraps    = (pre_exp[M-1:0] == {1'b1, {(M-1){1'b0}}});
      exp_rd   = {(wraps ? probe_of(pre_exp[N-1:M]) : 4'b0000), {M{1'b1}}};
      inc = 1'b1;
      #1;
      check(wr_mask == (pre_exp ^ post_exp), "R7 write mask", wr_mask, pre_exp ^ post_exp);
      check($countones(wr_mask) <= 3, "R7 write count", wr_mask, 3);
      check(rd_mask == exp_rd, "R8 read mask", rd_mask, exp_rd);
      @(negedge clk);
      check(state[M-1:0] == post_exp[M-1:0], "R3 fast Gray step", state, post_exp);
      check(state[N-1:M] == post_exp[N-1:M], wraps ? "R5 slow advance" : "R4 slow hold",
            state, post_exp);
      check(count == N'(v + 1), "R6 count", count, N'(v + 1));
    end
    check(state == '0, "R4 full wrap to zero", state, 0);

    // R2: idle cycles leave state alone and masks clear
    inc = 1'b1;
    repeat (21) @(negedge clk);
    inc = 1'b0;
    #1;
    check(rd_mask == '0 && wr_mask == '0, "R2 idle masks", {rd_mask, wr_mask}, 0);
    repeat (3) @(negedge clk);
    check(state == model_state(21), "R2 idle hold", state, model_state(21));
    check(count == N'(21), "R2 idle count", count, 21);

    // R9: slow transitions each flip at most two bits
    for (int k = 0; k < 16; k++)
      check($countones(SEQ[k] ^ SEQ[(k + 1) % 16]) <= 2, "R9 slow flips", SEQ[k], 2);

    // R1: asynchronous reset in mid count
    inc = 1'b1;
    #3;
    rst_n = 1'b0;
    #1;
    check(state == '0, "R1 async reset", state, 0);
    @(negedge clk);
    check(count == '0, "R1 reset held", count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(count == N'(1), "R6 first step after reset", count, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule